// File: doc/BRIEF.md
# Unsigned Compressor-Tree Multiplier

This block multiplies two unsigned operands and returns the full double-width product. It builds an AND-array of partial products, one shifted row per bit of the second operand. It then shrinks that stack to two rows with levels of 4:2 compressor cells. A plain carry-propagate addition of the last two rows gives the result. Each level halves the row count, so a 16-bit operand size needs three levels: 16 rows become 8, then 4, then 2.

Each 4:2 cell adds four equal-weight bits and one lateral carry from the cell one column to its right. The cell's fast output to the left is formed only from its own first two inputs and its third input. A row of cells therefore never ripples: every column settles after a fixed three-XOR depth. An output register, selected by a parameter and on by default, gives the product one cycle of latency for timing closure.

Top module: `cmp_tree_mul`

## Requirements
- R1: `prod` equals the unsigned product `op_a * op_b`, all 2*WIDTH bits, one clock after the operands are sampled on a rising edge of `clk`.
- R2: A rising edge with `rst_n` low loads zero into `prod`, whatever the operands are; the operands of that cycle never appear.
- R3: Each 4:2 cell satisfies x0+x1+x2+x3+cin = sum + 2*(carry + cout), where cout = (x0 xor x1) ? x2 : x0, which does not depend on cin.
- R4: Each row of cells keeps the arithmetic total: a+b+c+d = s + 2*cy + 2^N*(top lateral carry), with the lateral carry into column 0 tied to 0.
- R5: When either operand is zero, the product is 32'h0000_0000.
- R6: With both operands at 16'hFFFF, which fills every column of the matrix, the product is 32'hFFFE_0001.
- R7: When one operand is a single set bit at position k, the product equals the other operand shifted left by k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_a | input | WIDTH (16) | Multiplicand, unsigned |
| op_b | input | WIDTH (16) | Multiplier, unsigned |
| prod | output | 2*WIDTH (32) | Registered unsigned product |

## Verification
A zero operand shows that an empty matrix stays empty, and all-ones operands fill every column to its full height, so every cell and lateral carry is used. Walking single bits in either operand isolate one partial-product row at a time, which exposes a misrouted row or a wrong shift. Ten thousand random pairs mix carries and lateral carries in every column and expose errors in the cell equations. A reset asserted with nonzero operands shows that the register clears rather than loads.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    // Outputs of one 4:2 compressor cell.
    typedef struct packed {
        logic sum;    // weight n
        logic carry;  // weight n+1, goes to the next level
        logic cout;   // weight n+1, lateral carry to the next column
    } c42_out_t;

    // Row offset of level lvl inside the flattened row store.
    function automatic int unsigned lvl_base(input int unsigned width, input int unsigned lvl);
        return 2 * width - 2 * (width >> lvl);
    endfunction

endpackage

// File: rtl/mtp_cell42.sv
module mtp_cell42
    import mtp_pkg::*;
(
    input  logic     x0,
    input  logic     x1,
    input  logic     x2,
    input  logic     x3,
    input  logic     cin,
    output c42_out_t res
);

    logic p01;
    logic p23;
    logic p0123;

    always_comb begin
        p01       = x0 ^ x1;
        p23       = x2 ^ x3;
        p0123     = p01 ^ p23;
        res.cout  = p01 ? x2 : x0;
        res.sum   = p0123 ^ cin;
        res.carry = p0123 ? cin : x3;
    end

    // Weighted outputs must equal the count of set inputs.
    always_comb begin : chk_weight
        assert_cell_weight_R3: assert (int'(x0) + int'(x1) + int'(x2) + int'(x3) + int'(cin)
                == int'(res.sum) + 2 * (int'(res.carry) + int'(res.cout)))
            else $error("cell weight mismatch");
    end

endmodule

// File: rtl/mtp_row42.sv
module mtp_row42
    import mtp_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] ra,
    input  logic [N-1:0] rb,
    input  logic [N-1:0] rc,
    input  logic [N-1:0] rd,
    output logic [N-1:0] rs,
    output logic [N-1:0] rcy
);

    localparam int unsigned XW = N + 3;

    logic [N:0]   chain;
    logic [N-1:0] sums;
    logic [N-1:0] cys;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_col
        c42_out_t o;
        mtp_cell42 u_cell (
            .x0  (ra[i]),
            .x1  (rb[i]),
            .x2  (rc[i]),
            .x3  (rd[i]),
            .cin (chain[i]),
            .res (o)
        );
        assign sums[i]    = o.sum;
        assign cys[i]     = o.carry;
        assign chain[i+1] = o.cout;
    end

    assign rs  = sums;
    assign rcy = {cys[N-2:0], 1'b0};

    // Four rows in, weighted outputs out: the total must not change.
    always_comb begin : chk_total
        assert_row_total_R4: assert (XW'(ra) + XW'(rb) + XW'(rc) + XW'(rd)
                == XW'(sums) + (XW'(cys) << 1) + (XW'(chain[N]) << N))
            else $error("row total mismatch");
    end

endmodule

// File: rtl/mtp_ppgen.sv
module mtp_ppgen #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned PW    = 2 * WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [PW-1:0]    pp [WIDTH]
);

    for (genvar j = 0; j < WIDTH; j++) begin : g_row
        assign pp[j] = PW'(op_a & {WIDTH{op_b[j]}}) << j;
    end

endmodule

// File: rtl/cmp_tree_mul.sv
module cmp_tree_mul
    import mtp_pkg::*;
#(
    parameter int unsigned WIDTH   = 16,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] prod
);

    localparam int unsigned PW     = 2 * WIDTH;
    localparam int unsigned LVLS   = $clog2(WIDTH) - 1;
    localparam int unsigned NROWS  = 2 * WIDTH - 2;
    localparam int unsigned FINAL0 = lvl_base(WIDTH, LVLS);

    logic [PW-1:0] pp   [WIDTH];
    logic [PW-1:0] rows [NROWS];
    logic [PW-1:0] sum_w;

    mtp_ppgen #(
        .WIDTH (WIDTH),
        .PW    (PW)
    ) u_ppgen (
        .op_a (op_a),
        .op_b (op_b),
        .pp   (pp)
    );

    for (genvar j = 0; j < WIDTH; j++) begin : g_load
        assign rows[j] = pp[j];
    end

    // Each level turns every group of four rows into two.
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int unsigned IN_B  = lvl_base(WIDTH, l);
        localparam int unsigned OUT_B = lvl_base(WIDTH, l + 1);
        localparam int unsigned GRPS  = (WIDTH >> l) / 4;
        for (genvar g = 0; g < GRPS; g++) begin : g_grp
            mtp_row42 #(
                .N (PW)
            ) u_row (
                .ra  (rows[IN_B + 4*g]),
                .rb  (rows[IN_B + 4*g + 1]),
                .rc  (rows[IN_B + 4*g + 2]),
                .rd  (rows[IN_B + 4*g + 3]),
                .rs  (rows[OUT_B + 2*g]),
                .rcy (rows[OUT_B + 2*g + 1])
            );
        end
    end

    // Final carry-propagate addition of the last two rows.
    assign sum_w = rows[FINAL0] + rows[FINAL0 + 1];

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic [PW-1:0] prod;
        } out_t;

        out_t st_d;
        out_t st_q;

        always_comb begin
            st_d      = st_q;
            st_d.prod = sum_w;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign prod = st_q.prod;

        assert_prod_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> prod == $past(PW'(op_a) * PW'(op_b)))
            else $error("product mismatch");

        assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> prod == '0)
            else $error("product not cleared by reset");
    end else begin : g_comb
        assign prod = sum_w;
    end

endmodule

// File: tb/cmp_tree_mul_tb.sv
`timescale 1ns/1ps
module cmp_tree_mul_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = 16'h0;
    logic [15:0] op_b = 16'h0;
    logic [31:0] prod;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_tree_mul u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .op_a  (op_a),
        .op_b  (op_b),
        .prod  (prod)
    );

    // {op_a, op_b, expected}
    localparam logic [63:0] VEC [10] = '{
        {16'h0000, 16'h0000, 32'h0000_0000},
        {16'h0000, 16'hFFFF, 32'h0000_0000},
        {16'hFFFF, 16'h0000, 32'h0000_0000},
        {16'hFFFF, 16'hFFFF, 32'hFFFE_0001},
        {16'h0001, 16'h0001, 32'h0000_0001},
        {16'h8000, 16'h8000, 32'h4000_0000},
        {16'h8000, 16'hFFFF, 32'h7FFF_8000},
        {16'h1234, 16'h0001, 32'h0000_1234},
        {16'h00FF, 16'h00FF, 32'h0000_FE01},
        {16'h0003, 16'h0005, 32'h0000_000F}
    };

    function automatic string vec_tag(input int i);
        if (i < 3) return "R5";
        if (i == 3) return "R6";
        if (i < 8) return "R7";
        return "R1";
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, sample at the next fall.
    task automatic apply(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R2: reset state with nonzero operands present
        op_a = 16'h1234;
        op_b = 16'h5678;
        repeat (3) @(negedge clk);
        check(prod, 32'h0, "R2");
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < 10; i++) begin
            apply(VEC[i][63:48], VEC[i][47:32]);
            check(prod, VEC[i][31:0], vec_tag(i));
        end

        // R7: walking one in either operand
        for (int k = 0; k < 16; k++) begin
            apply(16'h1 << k, 16'hA5C3);
            check(prod, 32'h0000_A5C3 << k, "R7");
            apply(16'h3C5A, 16'h1 << k);
            check(prod, 32'h0000_3C5A << k, "R7");
        end

        // R2: reset asserted mid-run clears instead of loading
        apply(16'hFFFF, 16'hFFFF);
        check(prod, 32'hFFFE_0001, "R6");
        @(negedge clk);
        rst_n = 1'b0;
        op_a = 16'hBEEF;
        op_b = 16'hCAFE;
        @(negedge clk);
        check(prod, 32'h0, "R2");
        rst_n = 1'b1;

        // R1 with R3 and R4 exercised in every column: random pairs
        for (int n = 0; n < 10000; n++) begin
            logic [15:0] a;
            logic [15:0] b;
            a = 16'($urandom);
            b = 16'($urandom);
            apply(a, b);
            check(prod, 32'(a) * 32'(b), "R1,R3,R4");
        end

        finish_run();
    end

endmodule